// File: doc/BRIEF.md
# Per-Core Exclusive Reservation Monitor

This block keeps the reservation state that backs load-exclusive / store-exclusive sequences on one processor core. It watches each memory request the core issues and records a reservation when a load-exclusive arrives. The reservation is the address with its low bits dropped, so any address in the same aligned granule matches it. When a store-exclusive arrives, the block decides in the same cycle whether that store may reach memory. It drives a write permit and a status flag: 0 means the store went through, 1 means it was refused.

The monitor has two states, open and exclusive. A plain store that hits the reserved granule, an explicit clear request, any store-exclusive, and an exception or context-switch pulse all return it to open. A new load-exclusive always replaces the old reservation. Cache coherence, the memory and cross-core arbitration are outside this block. It only gates whether an exclusive store may commit.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is open, the tag reads 0, and with no request both `stxFail` and `stxPermit` are 0.
- R2: A load-exclusive (`reqKind`=0) with `reqValid` high makes the monitor exclusive at the next edge. It also loads the tag with `reqAddr[ADDR_W-1:GRANULE_LOG2]`, overwriting any earlier reservation.
- R3: For a valid store-exclusive (`reqKind`=1), the outputs are combinational in the request cycle. `stxPermit`=1 with `stxFail`=0 means the store commits; `stxPermit`=0 with `stxFail`=1 means it is refused. For any other request, both outputs are 0.
- R4: A store-exclusive commits only when the monitor is exclusive and `reqAddr[ADDR_W-1:GRANULE_LOG2]` equals the tag. Any address inside the reserved granule matches.
- R5: A store-exclusive while the monitor is open always fails and never raises `stxPermit`.
- R6: Every valid store-exclusive, whether it passes or fails, leaves the monitor open after the next edge.
- R7: A plain store (`reqKind`=2) outside the reserved granule leaves the state unchanged. One inside the granule while exclusive makes the monitor open.
- R8: A clear request (`reqKind`=3) makes the monitor open at the next edge.
- R9: A high `flushPulse` acts like a clear request. If it comes in the same cycle as a valid load-exclusive, the load-exclusive wins and the monitor becomes exclusive. The outcome of a store-exclusive in the same cycle uses the state held before the pulse.
- R10: With `reqValid` low, `reqKind` and `reqAddr` have no effect on the state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqKind | input | 2 | 0 load-excl, 1 store-excl, 2 plain store, 3 clear |
| reqAddr | input | ADDR_W | Request byte address |
| flushPulse | input | 1 | Exception entry or context switch clear |
| stxFail | output | 1 | Store-exclusive status (1 = refused) |
| stxPermit | output | 1 | Store-exclusive may write memory |
| monExclusive | output | 1 | Monitor is in the exclusive state |
| monTag | output | ADDR_W-GRANULE_LOG2 | Reserved granule tag |

## Verification
`stxFail` and `stxPermit` belong to the request cycle, so the bench drives each request at a falling edge. It reads these two outputs a few nanoseconds later, before the next rising edge. `monExclusive` and `monTag` change one rising edge after the request, so the bench reads them a few nanoseconds after that edge. This keeps every sample clear of the edge itself. The vector table runs through overwrite, granule-aliasing, plain-store and flush-collision orderings. Directed tests then cover reset, including a reset taken while the monitor is exclusive.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    KIND_LDEX  = 2'd0,
    KIND_STEX  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_CLEAR = 2'd3
  } req_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setTag;   // capture new reservation, go exclusive
    logic goOpen;   // drop to open
  } mon_strb_t;

endpackage

// File: rtl/excl_mon_dpath.sv
module excl_mon_dpath
  import excl_mon_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  mon_strb_t        strb,
  input  logic [TAG_W-1:0] reqTag,
  output logic             monExcl,
  output logic [TAG_W-1:0] monTag,
  output logic             tagMatch
);

  logic             exclQ;
  logic [TAG_W-1:0] tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exclQ <= 1'b0;
      tagQ  <= '0;
    end else if (strb.setTag) begin
      exclQ <= 1'b1;
      tagQ  <= reqTag;
    end else if (strb.goOpen) begin
      exclQ <= 1'b0;
    end
  end

  assign tagMatch = (tagQ == reqTag);
  assign monExcl  = exclQ;
  assign monTag   = tagQ;

endmodule

// File: rtl/excl_mon_ctrl.sv
module excl_mon_ctrl
  import excl_mon_pkg::*;
(
  input  logic      reqValid,
  input  req_kind_e reqKind,
  input  logic      flushPulse,
  input  logic      monExcl,
  input  logic      tagMatch,
  output mon_strb_t strb,
  output logic      stxFail,
  output logic      stxPermit
);

  logic isLdex, isStex, isStore, isClear, hitResv;

  always_comb begin
    isLdex  = reqValid && (reqKind == KIND_LDEX);
    isStex  = reqValid && (reqKind == KIND_STEX);
    isStore = reqValid && (reqKind == KIND_STORE);
    isClear = reqValid && (reqKind == KIND_CLEAR);
    hitResv = monExcl && tagMatch;

    stxPermit = isStex && hitResv;
    stxFail   = isStex && !hitResv;

    strb.setTag = isLdex;
    strb.goOpen = isStex || isClear || flushPulse || (isStore && hitResv);
  end

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GRANULE_LOG2 = 6,
  localparam int TAG_W       = ADDR_W - GRANULE_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              flushPulse,
  output logic              stxFail,
  output logic              stxPermit,
  output logic              monExclusive,
  output logic [TAG_W-1:0]  monTag
);

  mon_strb_t        strb;
  logic [TAG_W-1:0] reqTag;
  logic             tagMatch;
  logic             unusedLowBits;
  req_kind_e        kindE;

  assign reqTag        = reqAddr[ADDR_W-1:GRANULE_LOG2];
  assign unusedLowBits = ^reqAddr[GRANULE_LOG2-1:0];
  assign kindE         = req_kind_e'(reqKind);

  excl_mon_ctrl ctrl_i (
    .reqValid  (reqValid),
    .reqKind   (kindE),
    .flushPulse(flushPulse),
    .monExcl   (monExclusive),
    .tagMatch  (tagMatch),
    .strb      (strb),
    .stxFail   (stxFail),
    .stxPermit (stxPermit)
  );

  excl_mon_dpath #(.TAG_W(TAG_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqTag  (reqTag),
    .monExcl (monExclusive),
    .monTag  (monTag),
    .tagMatch(tagMatch)
  );

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int ADDR_W       = 32,
  parameter int GRANULE_LOG2 = 6,
  localparam int TAG_W       = ADDR_W - GRANULE_LOG2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              flushPulse,
  input logic              stxFail,
  input logic              stxPermit,
  input logic              monExclusive,
  input logic [TAG_W-1:0]  monTag
);

  logic [TAG_W-1:0] addrTag;
  logic             unusedChkBits;
  assign addrTag       = reqAddr[ADDR_W-1:GRANULE_LOG2];
  assign unusedChkBits = ^reqAddr[GRANULE_LOG2-1:0];

  // R2
  ldex_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> (monExclusive && monTag == $past(addrTag)));

  // R3
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stxFail && stxPermit));

  // R4
  permit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    stxPermit |-> (monExclusive && monTag == addrTag && reqValid && reqKind == 2'd1));

  // R5
  open_stx_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd1 && !monExclusive) |-> (stxFail && !stxPermit));

  // R6
  stx_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd1) |=> !monExclusive);

  // R8
  clear_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd3) |=> !monExclusive);

  // R9
  flush_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushPulse && !(reqValid && reqKind == 2'd0)) |=> !monExclusive);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !flushPulse) |=> ($stable(monExclusive) && $stable(monTag)));

endmodule

bind excl_mon_top excl_mon_chk #(.ADDR_W(ADDR_W), .GRANULE_LOG2(GRANULE_LOG2)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqKind     (reqKind),
  .reqAddr     (reqAddr),
  .flushPulse  (flushPulse),
  .stxFail     (stxFail),
  .stxPermit   (stxPermit),
  .monExclusive(monExclusive),
  .monTag      (monTag)
);

// File: tb/excl_mon_top_tb_top.sv
module excl_mon_top_tb_top;

  localparam int ADDR_W = 32;
  localparam int GL2    = 6;
  localparam int TAG_W  = ADDR_W - GL2;
  localparam int NVEC   = 17;

  typedef struct packed {
    logic              valid;
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic              flush;
    logic              eFail;
    logic              ePermit;
    logic              eExcl;
    logic              chkTag;
    logic [TAG_W-1:0]  eTag;
  } vec_t;

  // kind: 0 ldex, 1 stex, 2 store, 3 clear
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd1, 32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R5 open stex
    '{1'b1, 2'd0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h40},  // R2
    '{1'b1, 2'd2, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h40},  // R7 miss
    '{1'b1, 2'd1, 32'h0000_1038, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 26'h0},   // R4 same granule
    '{1'b1, 2'd0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h40},  // R2
    '{1'b1, 2'd0, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'hC0},  // R2 overwrite
    '{1'b1, 2'd1, 32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R4 R6 mismatch
    '{1'b1, 2'd0, 32'h0000_3004, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'hC0},  // R2
    '{1'b1, 2'd2, 32'h0000_3020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 hit
    '{1'b1, 2'd0, 32'h0000_0500, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h14},  // R2
    '{1'b1, 2'd3, 32'h0000_0500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R8
    '{1'b1, 2'd0, 32'h0000_0500, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h14},  // R2
    '{1'b0, 2'd1, 32'h0000_0500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R9 flush, R10
    '{1'b1, 2'd1, 32'h0000_0500, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R5
    '{1'b1, 2'd0, 32'h0000_0700, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 26'h1C},  // R9 ldex wins
    '{1'b1, 2'd1, 32'h0000_0700, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 26'h0},   // R9 stex sees old state
    '{1'b0, 2'd0, 32'h0000_0900, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h1C}   // R10 idle ldex ignored
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqKind;
  logic [ADDR_W-1:0] reqAddr;
  logic              flushPulse;
  logic              stxFail;
  logic              stxPermit;
  logic              monExclusive;
  logic [TAG_W-1:0]  monTag;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  excl_mon_top #(.ADDR_W(ADDR_W), .GRANULE_LOG2(GL2)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .flushPulse(flushPulse), .stxFail(stxFail),
    .stxPermit(stxPermit), .monExclusive(monExclusive), .monTag(monTag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [ADDR_W-1:0] a,
                       input logic f);
    @(negedge clk);
    reqValid = v; reqKind = k; reqAddr = a; flushPulse = f;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqAddr = '0; flushPulse = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 excl", {31'b0, monExclusive}, 32'd0);
    check("R1 tag", {6'b0, monTag}, 32'd0);
    check("R1 fail", {31'b0, stxFail}, 32'd0);
    check("R1 permit", {31'b0, stxPermit}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].valid, VEC[i].kind, VEC[i].addr, VEC[i].flush);
      #2;
      check($sformatf("R3 fail v%0d", i), {31'b0, stxFail}, {31'b0, VEC[i].eFail});
      check($sformatf("R4 permit v%0d", i), {31'b0, stxPermit}, {31'b0, VEC[i].ePermit});
      @(posedge clk); #2;
      check($sformatf("R6 R7 state v%0d", i), {31'b0, monExclusive}, {31'b0, VEC[i].eExcl});
      if (VEC[i].chkTag)
        check($sformatf("R2 tag v%0d", i), {6'b0, monTag}, {6'b0, VEC[i].eTag});
    end

    // R10 idle store-exclusive raises no outputs (state exclusive? no: open) - test when exclusive
    drive(1'b1, 2'd0, 32'h0000_0A00, 1'b0);
    drive(1'b0, 2'd2, 32'h0000_0A00, 1'b0);
    #2;
    check("R10 idle fail", {31'b0, stxFail}, 32'd0);
    @(posedge clk); #2;
    check("R10 idle store kept excl", {31'b0, monExclusive}, 32'd1);
    check("R2 tag kept", {6'b0, monTag}, 32'h28);

    // R1 reset while exclusive returns to open and clears tag
    drive(1'b0, 2'd0, '0, 1'b0);
    rstN = 1'b0;
    @(posedge clk); #2;
    check("R1 reset excl", {31'b0, monExclusive}, 32'd0);
    check("R1 reset tag", {6'b0, monTag}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    drive(1'b1, 2'd1, 32'h0000_0A00, 1'b0);
    #2;
    check("R5 after reset stex fails", {31'b0, stxFail}, 32'd1);
    @(negedge clk); reqValid = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule